// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the address sequence for a four-beat memory burst. A burst begins when either of two start strobes is high at a rising clock edge: one strobe serves a processor-side master, the other a cache-controller-side master. On that edge the block captures the full input address. The two low bits of that address become the starting beat, and an internal two-bit beat counter clears to zero.

On each later edge where the advance input is high, the beat counter steps by one. It wraps inside the four-beat group and never carries into the upper address bits. Those upper bits stay in a register for the whole burst.

A mode input picks the order of the low two bits. When it is low, the order is linear: start plus count, modulo four. When it is high, the order is interleaved: start XOR count. The high setting is the expected strap value when the pin is otherwise unused. The mode level is applied combinationally to the registered state.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is active and after it is released, with no strobe asserted, `burstAddr` is all zeros.
- R2: If `startProc` or `startCache` is high at a rising edge, `burstAddr` equals the value `addrIn` had at that edge after the edge, in either order mode.
- R3: If both start strobes are high at the same edge, the burst loads exactly as if only one of them were high.
- R4: With `modeInterleave` low, `burstAddr[1:0]` equals (start + count) mod 4. Here start is the captured `addrIn[1:0]` and count is the number of advance edges since the load.
- R5: With `modeInterleave` high, `burstAddr[1:0]` equals start XOR count.
- R6: On an edge with no start strobe and `advance` low, the beat count and captured address are unchanged, and `addrIn` has no effect.
- R7: After the fourth advance the sequence returns to the start beat. The bits `burstAddr[ADDR_W-1:2]` never change between loads, including on a step from beat 3 to beat 0.
- R8: If a start strobe and `advance` are high on the same edge, the load wins and the count is zero afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all captured inputs |
| rstN | input | 1 | Active-low asynchronous reset |
| startProc | input | 1 | Burst start strobe from the processor-side master |
| startCache | input | 1 | Burst start strobe from the cache-controller-side master |
| advance | input | 1 | Step the beat counter on this edge |
| modeInterleave | input | 1 | 1 selects interleaved order, 0 selects linear order |
| addrIn | input | ADDR_W | Burst base address captured on a start |
| burstAddr | output | ADDR_W | Current burst address |

## Verification
A load or an advance takes effect one edge after the inputs are presented: the block has one register stage, and `burstAddr` reflects it as soon as that edge has passed. The mode input acts with no clock at all. The bench therefore drives every input at the falling edge and lets one rising edge pass. It compares `burstAddr` at the next falling edge, before new inputs are driven, so the mode level under test is still applied at that point. Reset is checked while it is held and again after release, before any strobe.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  localparam int BEAT_W = 2;

  typedef struct packed {
    logic load;
    logic step;
  } burstCtl_t;
endpackage

// File: rtl/burst_addr_ctl.sv
module burst_addr_ctl
  import burst_addr_pkg::*;
(
  input  logic      startProc,
  input  logic      startCache,
  input  logic      advance,
  output burstCtl_t ctl
);
  // A start from either master wins over an advance on the same edge (R8).
  always_comb begin
    ctl.load = startProc | startCache;
    ctl.step = advance & ~(startProc | startCache);
  end
endmodule

// File: rtl/burst_addr_dp.sv
module burst_addr_dp
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  burstCtl_t         ctl,
  input  logic              modeInterleave,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] burstAddr
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] baseReg;
  logic [BEAT_W-1:0] countReg;
  logic [BEAT_W-1:0] beatBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg  <= '0;
      countReg <= '0;
    end else if (ctl.load) begin
      baseReg  <= addrIn;
      countReg <= '0;
    end else if (ctl.step) begin
      countReg <= countReg + 1'b1;
    end
  end

  always_comb begin
    if (modeInterleave) beatBits = baseReg[BEAT_W-1:0] ^ countReg;
    else                beatBits = baseReg[BEAT_W-1:0] + countReg;
  end

  assign burstAddr = {baseReg[ADDR_W-1:BEAT_W], beatBits};

  a_r2_load_capture: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> baseReg == $past(addrIn));

  a_r8_load_clears_count: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> countReg == '0);

  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.step) |=> ($stable(countReg) && $stable(baseReg)));

  a_r7_upper_fixed: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(burstAddr[ADDR_W-1:BEAT_W]));

  a_r4_step_by_one: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> countReg == BEAT_W'($past(countReg) + 1'b1));

  a_r5_interleave_start: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && modeInterleave) |=> (!modeInterleave ||
      burstAddr[BEAT_W-1:0] == $past(addrIn[BEAT_W-1:0])));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startProc,
  input  logic              startCache,
  input  logic              advance,
  input  logic              modeInterleave,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] burstAddr
);
  burstCtl_t ctl;

  burst_addr_ctl u_ctl (
    .startProc (startProc),
    .startCache(startCache),
    .advance   (advance),
    .ctl       (ctl)
  );

  burst_addr_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .modeInterleave(modeInterleave),
    .addrIn        (addrIn),
    .burstAddr     (burstAddr)
  );
endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  localparam int AW = 19;
  localparam int NV = 18;
  localparam int VW = 4 + 4 + AW + AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startProc = 1'b0, startCache = 1'b0, advance = 1'b0, modeInterleave = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [AW-1:0] burstAddr;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u_burst_addr_gen (
    .clk(clk), .rstN(rstN), .startProc(startProc), .startCache(startCache),
    .advance(advance), .modeInterleave(modeInterleave), .addrIn(addrIn),
    .burstAddr(burstAddr)
  );

  // Row: {req, startProc, startCache, advance, mode, addrIn, expected}
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd2, 4'b1000, 19'h12342, 19'h12342},  // R2 processor start, linear
    {4'd4, 4'b0010, 19'h00000, 19'h12343},  // R4
    {4'd4, 4'b0010, 19'h00000, 19'h12340},  // R4 and R7: low bits wrap
    {4'd4, 4'b0010, 19'h00000, 19'h12341},  // R4
    {4'd7, 4'b0010, 19'h00000, 19'h12342},  // R7 back to the start beat
    {4'd6, 4'b0000, 19'h7FFFF, 19'h12342},  // R6 idle, addrIn ignored
    {4'd2, 4'b0101, 19'h0ABC5, 19'h0ABC5},  // R2 cache start, interleaved
    {4'd5, 4'b0011, 19'h00000, 19'h0ABC4},  // R5
    {4'd5, 4'b0011, 19'h00000, 19'h0ABC7},  // R5
    {4'd5, 4'b0011, 19'h00000, 19'h0ABC6},  // R5
    {4'd7, 4'b0011, 19'h00000, 19'h0ABC5},  // R7 interleaved wrap
    {4'd3, 4'b1111, 19'h55553, 19'h55553},  // R3 and R8: both starts plus advance
    {4'd8, 4'b0011, 19'h00000, 19'h55552},  // R8 count was zero, now one
    {4'd4, 4'b0010, 19'h00000, 19'h55551},  // R4 switch to linear, count two
    {4'd8, 4'b0110, 19'h00001, 19'h00001},  // R8 cache start beats advance
    {4'd6, 4'b0010, 19'h7FFFF, 19'h00002},  // R6 addrIn ignored during advance
    {4'd2, 4'b0100, 19'h3FFFF, 19'h3FFFF},  // R2 start at beat 3
    {4'd7, 4'b0010, 19'h00000, 19'h3FFFC}   // R7 no carry into upper bits
  };

  task automatic check(input logic [AW-1:0] exp, input int req, input string what);
    checks++;
    if (burstAddr !== exp) begin
      errors++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, burstAddr, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic [AW-1:0] a);
    {startProc, startCache, advance, modeInterleave} = c;
    addrIn = a;
  endtask

  initial begin
    #15 check('0, 1, "R1 during reset");
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check('0, 1, "R1 after release");

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][VW-5 -: 4], VEC[i][2*AW-1 -: AW]);
      @(negedge clk);
      check(VEC[i][AW-1:0], int'(VEC[i][VW-1 -: 4]), $sformatf("table row %0d", i));
    end

    // R6: several idle edges with a changing addrIn hold the address.
    for (int k = 0; k < 3; k++) begin
      drive(4'b0000, 19'h1F0F0 + AW'(k));
      @(negedge clk);
      check(19'h3FFFC, 6, "R6 idle hold");
    end

    // R5: interleaved from beat 2 runs 2,3,0,1.
    drive(4'b1001, 19'h40002); @(negedge clk); check(19'h40002, 5, "R5 start 2");
    drive(4'b0011, '0);        @(negedge clk); check(19'h40003, 5, "R5 beat 1");
    drive(4'b0011, '0);        @(negedge clk); check(19'h40000, 5, "R5 beat 2");
    drive(4'b0011, '0);        @(negedge clk); check(19'h40001, 5, "R5 beat 3");

    // R1: reset in the middle of a burst returns to zero.
    drive(4'b0000, '0);
    rstN = 1'b0;
    #1 check('0, 1, "R1 mid-burst reset");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check('0, 1, "R1 after second release");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule